// File: doc/BRIEF.md
# Operand and address size resolver

This block sits at the front of an instruction decoder. It receives the instruction stream one byte per cycle over a valid/ready handshake. It works out three size attributes for each instruction: the operand width, the address width and the stack address width. Each attribute is either 16 or 32 bits.

Each attribute starts from a default. The default comes from the processor mode and one segment descriptor bit. The operand-size override byte (66h) and the address-size override byte (67h) invert the operand and address defaults for the instruction that carries them. The resolver consumes these override bytes and does not pass them on. It forwards only the first byte that is not an override, together with the resolved attributes, through a one-entry output register. After that byte is taken, the override state clears, so the next instruction starts again from the defaults.

Other prefixes, opcode decoding and instruction length are handled elsewhere.

Top module: `size_attr_resolver`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The mode encoding is 00 = real, 01 = virtual-8086, 10 = protected; 11 is treated as protected. In a protected mode with no override byte, `out_op32` and `out_addr32` both equal `code_dbit`. Attribute encoding is 1 = 32-bit, 0 = 16-bit.
- R3: In real or virtual-8086 mode with no override byte, `out_op32` and `out_addr32` are both 0, whatever `code_dbit` is.
- R4: An accepted byte 66h is never forwarded. It inverts `out_op32` of the next forwarded byte relative to the default.
- R5: An accepted byte 67h is never forwarded. It inverts `out_addr32` of the next forwarded byte relative to the default.
- R6: When both override bytes precede an opcode, in either order, each inverts only its own attribute.
- R7: Repeating an override byte of the same kind has the same effect as a single one. It does not invert the attribute back.
- R8: After a non-override byte is accepted, the override state is cleared, so the following instruction resolves to the defaults.
- R9: `out_stk32` equals `stack_bbit` in a protected mode and is 0 in real or virtual-8086 mode. Override bytes never change it.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_byte` and the attributes hold steady, `in_ready` is 0, and no input byte is taken.
- R11: When an output is drained, a new byte can be accepted in the same cycle, so a back-to-back stream flows at one byte per cycle. A forwarded byte appears on the output the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_mode | input | 2 | Processor mode (00 real, 01 virtual-8086, 1x protected) |
| code_dbit | input | 1 | Default-size bit of the code segment descriptor |
| stack_bbit | input | 1 | Size bit of the stack segment descriptor |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_valid | output | 1 | Forwarded byte and attributes are valid |
| out_byte | output | 8 | First non-override byte of the instruction |
| out_op32 | output | 1 | Resolved operand size, 1 = 32-bit |
| out_addr32 | output | 1 | Resolved address size, 1 = 32-bit |
| out_stk32 | output | 1 | Stack address size, 1 = 32-bit |
| out_ready | input | 1 | Consumer takes the output |

## Verification
Two functions can fall in the same cycle: draining the previous instruction's result and accepting the next instruction's first override byte. The back-to-back sweep provokes this on every instruction boundary by holding `out_ready` high and streaming bytes with no gaps. Each such cycle is judged by two checks: `out_valid` must drop after the override is taken, and the following opcode must still carry the inverted attribute. A separate stall case holds `out_ready` low while an opcode waits at the input, then checks that the old output stays put and that the waiting byte is taken only on release.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    MODE_REAL     = 2'b00,
    MODE_V86      = 2'b01,
    MODE_PROT     = 2'b10,
    MODE_PROT_ALT = 2'b11
  } cpu_mode_e;

  typedef struct packed {
    logic op32;
    logic addr32;
    logic stk32;
  } size_attr_t;

  localparam int unsigned NUM_PFX_KINDS = 2;
  localparam int unsigned PFX_IDX_OP    = 0;
  localparam int unsigned PFX_IDX_ADDR  = 1;

endpackage

// File: rtl/sar_default_sel.sv
module sar_default_sel
  import sar_pkg::*;
(
  input  cpu_mode_e  mode,
  input  logic       code_d,
  input  logic       stack_b,
  output size_attr_t dflt
);

  logic prot_mode;

  always_comb begin
    prot_mode   = (mode == MODE_PROT) || (mode == MODE_PROT_ALT);
    dflt.op32   = prot_mode & code_d;
    dflt.addr32 = prot_mode & code_d;
    dflt.stk32  = prot_mode & stack_b;
  end

endmodule

// File: rtl/sar_prefix_track.sv
module sar_prefix_track
  import sar_pkg::*;
#(
  parameter int unsigned           BYTE_W  = 8,
  parameter logic [BYTE_W-1:0]     OP_PFX  = 8'h66,
  parameter logic [BYTE_W-1:0]     AD_PFX  = 8'h67
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_fire,
  input  logic [BYTE_W-1:0]        byte_in,
  output logic                     is_pfx,
  output logic [NUM_PFX_KINDS-1:0] flip
);

  localparam logic [NUM_PFX_KINDS-1:0][BYTE_W-1:0] PFX_CODES = {AD_PFX, OP_PFX};

  logic [NUM_PFX_KINDS-1:0] match;
  logic [NUM_PFX_KINDS-1:0] flag_d;
  logic [NUM_PFX_KINDS-1:0] flag_q;

  for (genvar k = 0; k < NUM_PFX_KINDS; k++) begin : g_kind
    always_comb begin
      match[k] = (byte_in == PFX_CODES[k]);
    end
  end

  always_comb begin
    is_pfx = |match;
  end

  for (genvar k = 0; k < NUM_PFX_KINDS; k++) begin : g_next
    always_comb begin
      flag_d[k] = flag_q[k];
      if (byte_fire) begin
        if (match[k]) begin
          flag_d[k] = 1'b1;
        end else if (!is_pfx) begin
          flag_d[k] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    flip = flag_q;
  end

  // R7
  repeat_pfx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && match[PFX_IDX_OP] && flag_q[PFX_IDX_OP]) |=> flag_q[PFX_IDX_OP]);

  // R8
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fire && !is_pfx) |=> (flag_q == '0));

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
  import sar_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  size_attr_t        load_attr,
  input  logic              out_ready,
  output logic              can_accept,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output size_attr_t        out_attr
);

  logic              valid_d, valid_q;
  logic [BYTE_W-1:0] byte_q;
  size_attr_t        attr_q;

  always_comb begin
    can_accept = !valid_q || out_ready;
    valid_d    = valid_q;
    if (load) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      attr_q <= '0;
    end else if (load) begin
      byte_q <= load_byte;
      attr_q <= load_attr;
    end
  end

  always_comb begin
    out_valid = valid_q;
    out_byte  = byte_q;
    out_attr  = attr_q;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(byte_q) && $stable(attr_q)));

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && out_ready && !load) |=> !valid_q);

endmodule

// File: rtl/size_attr_resolver.sv
module size_attr_resolver
  import sar_pkg::*;
#(
  parameter int unsigned           BYTE_W = 8,
  parameter logic [BYTE_W-1:0]     OP_PFX = 8'h66,
  parameter logic [BYTE_W-1:0]     AD_PFX = 8'h67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cpu_mode,
  input  logic              code_dbit,
  input  logic              stack_bbit,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_op32,
  output logic              out_addr32,
  output logic              out_stk32,
  input  logic              out_ready
);

  size_attr_t               dflt;
  size_attr_t               resolved;
  size_attr_t               held_attr;
  logic [NUM_PFX_KINDS-1:0] flip;
  logic                     is_pfx;
  logic                     can_accept;
  logic                     byte_fire;
  logic                     load;

  sar_default_sel u_dflt (
    .mode    (cpu_mode_e'(cpu_mode)),
    .code_d  (code_dbit),
    .stack_b (stack_bbit),
    .dflt    (dflt)
  );

  sar_prefix_track #(
    .BYTE_W (BYTE_W),
    .OP_PFX (OP_PFX),
    .AD_PFX (AD_PFX)
  ) u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_fire (byte_fire),
    .byte_in   (in_byte),
    .is_pfx    (is_pfx),
    .flip      (flip)
  );

  always_comb begin
    byte_fire       = in_valid && can_accept;
    load            = byte_fire && !is_pfx;
    resolved.op32   = dflt.op32   ^ flip[PFX_IDX_OP];
    resolved.addr32 = dflt.addr32 ^ flip[PFX_IDX_ADDR];
    resolved.stk32  = dflt.stk32;
  end

  sar_out_stage #(
    .BYTE_W (BYTE_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_byte  (in_byte),
    .load_attr  (resolved),
    .out_ready  (out_ready),
    .can_accept (can_accept),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_attr   (held_attr)
  );

  always_comb begin
    in_ready   = can_accept;
    out_op32   = held_attr.op32;
    out_addr32 = held_attr.addr32;
    out_stk32  = held_attr.stk32;
  end

  // R4
  no_pfx_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_byte != OP_PFX) && (out_byte != AD_PFX)));

  // R9
  real_stack16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cpu_mode[1]) |=> !out_stk32);

endmodule

// File: tb/size_attr_resolver_tb_top.sv
module size_attr_resolver_tb_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] cpu_mode;
  logic       code_dbit;
  logic       stack_bbit;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_op32;
  logic       out_addr32;
  logic       out_stk32;
  logic       out_ready;

  int n_tests;
  int n_fail;
  bit done;

  size_attr_resolver dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_mode   (cpu_mode),
    .code_dbit  (code_dbit),
    .stack_bbit (stack_bbit),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_op32   (out_op32),
    .out_addr32 (out_addr32),
    .out_stk32  (out_stk32),
    .out_ready  (out_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Presents one byte at a negedge, lets one edge pass, returns at the next negedge.
  task automatic xfer(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    chk("R11 in_ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_instr(input int npfx, input int code, input logic [7:0] opc);
    logic prot, has66, has67, dup66, dup67, eop, ead, est;
    int c66, c67;
    string rop, rad;
    prot = cpu_mode[1];
    c66 = 0;
    c67 = 0;
    for (int i = 0; i < npfx; i++) begin
      if (code[i]) begin
        c67++;
        xfer(8'h67);
        chk("R5 prefix not forwarded", {31'd0, out_valid}, 32'd0);
      end else begin
        c66++;
        xfer(8'h66);
        chk("R4 prefix not forwarded", {31'd0, out_valid}, 32'd0);
      end
    end
    has66 = (c66 > 0);
    has67 = (c67 > 0);
    dup66 = (c66 > 1);
    dup67 = (c67 > 1);
    eop = (prot & code_dbit) ^ has66;
    ead = (prot & code_dbit) ^ has67;
    est = prot & stack_bbit;
    xfer(opc);
    in_valid = 1'b0;
    if (!has66) rop = prot ? "R2 op default" : "R3 op default";
    else if (dup66) rop = "R7 op repeat";
    else if (has67) rop = "R6 op both";
    else rop = "R4 op flip";
    if (!has67) rad = prot ? "R2 addr default" : "R3 addr default";
    else if (dup67) rad = "R7 addr repeat";
    else if (has66) rad = "R6 addr both";
    else rad = "R5 addr flip";
    chk("R11 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R11 out_byte", {24'd0, out_byte}, {24'd0, opc});
    chk(rop, {31'd0, out_op32}, {31'd0, eop});
    chk(rad, {31'd0, out_addr32}, {31'd0, ead});
    chk("R9 stack", {31'd0, out_stk32}, {31'd0, est});
  endtask

  initial begin
    n_tests = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    cpu_mode = 2'b00;
    code_dbit = 1'b1;
    stack_bbit = 1'b1;
    in_valid = 1'b0;
    in_byte = 8'h00;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 post-reset in_ready", {31'd0, in_ready}, 32'd1);

    // Sweep: mode x descriptor bits x override sequences up to three long, back to back.
    for (int m = 0; m < 4; m++) begin
      for (int db = 0; db < 4; db++) begin
        cpu_mode   = m[1:0];
        code_dbit  = db[0];
        stack_bbit = db[1];
        for (int n = 0; n <= 3; n++) begin
          for (int c = 0; c < (1 << n); c++) begin
            send_instr(n, c, 8'h50 + 8'(c) + 8'(n * 8));
          end
        end
      end
    end

    // R8: a flipped instruction followed by a bare one resolves to defaults.
    cpu_mode = 2'b10;
    code_dbit = 1'b0;
    stack_bbit = 1'b0;
    xfer(8'h66);
    xfer(8'h67);
    xfer(8'h8B);
    in_valid = 1'b0;
    chk("R6 flipped op", {31'd0, out_op32}, 32'd1);
    xfer(8'h5A);
    in_valid = 1'b0;
    chk("R8 op back to default", {31'd0, out_op32}, 32'd0);
    chk("R8 addr back to default", {31'd0, out_addr32}, 32'd0);

    // R10: stall with an opcode waiting at the input.
    xfer(8'h66);
    xfer(8'hA1);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_byte = 8'h90;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10 in_ready low", {31'd0, in_ready}, 32'd0);
      chk("R10 out_valid held", {31'd0, out_valid}, 32'd1);
      chk("R10 out_byte held", {24'd0, out_byte}, 32'hA1);
      chk("R10 op held", {31'd0, out_op32}, 32'd1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 released byte", {24'd0, out_byte}, 32'h90);
    chk("R10 released valid", {31'd0, out_valid}, 32'd1);
    chk("R8 released op default", {31'd0, out_op32}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R11 drained", {31'd0, out_valid}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule